// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the bit-rate timing for a serial transmitter. It does not divide the clock by an integer. Each enabled clock cycle it adds a 16-bit step value to a 20-bit phase accumulator. Every time that addition wraps past 2^20, it emits a single-cycle tick. The average tick rate is therefore step × f_clk / 2^20, which gives fine baud resolution from any system clock. For example, at 50 MHz the step that gives 230400 baud is about 4832.

A second stage counts the bit ticks and raises a character-done pulse on every tenth one. Ten bit times cover one start bit, eight data bits and one stop bit. A new step value is used from the very next addition, with no resynchronisation. Dropping the enable, or asserting the synchronous reset, clears the accumulator phase and the bit count.

Top module: `nco_baud_gen`

## Requirements
- R1: After synchronous reset both outputs are 0 and the accumulator phase is 0. With a constant step S applied from reset release, the first tick appears exactly ceil(2^20 / S) enabled cycles later.
- R2: Each enabled clock edge adds the step to the 20-bit phase. The tick output is 1 for exactly the one cycle that follows an edge whose addition carried out of bit 19, and 0 otherwise.
- R3: Starting from a cleared phase with a constant step S, the number of ticks seen in N enabled cycles is floor(N × S / 2^20).
- R4: A step of zero produces no ticks and no character-done pulses.
- R5: char_done is 1 in the same cycle as every tenth tick counted since the phase and count were last cleared, and it is 0 in all other cycles.
- R6: While enable is 0 both outputs are 0. The phase and the bit count are cleared, so after re-enabling, the tick timing and the character count start from zero.
- R7: A change of step takes effect on the first enabled edge at which the new value is present. No earlier additions are affected.
- R8: The largest step, 0xFFFF, never yields ticks on two consecutive cycles. Its tick count still follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when 0, clears phase and bit count |
| step | input | 16 | Phase increment added each enabled cycle |
| bit_tick | output | 1 | One-cycle pulse at the bit rate |
| char_done | output | 1 | One-cycle pulse coinciding with every tenth bit tick |

## Verification
Both outputs are registered, so each result is due one clock after the edge that sees the inputs causing it. A wrapping addition at edge k shows as bit_tick high between edges k and k+1, and char_done follows the same rule. The bench applies inputs on falling edges. At every rising edge, a bench model advances from those inputs, and the outputs are compared on the next falling edge, so each expected value lines up with the register that produces it. Window counts (R3, R8) and the first-tick latency (R1) are summed over the same falling-edge samples.

// File: rtl/nco_baud_pkg.sv
package nco_baud_pkg;

   // Default geometry of the generator
   localparam int unsigned NCO_ACC_W     = 20;
   localparam int unsigned NCO_STEP_W    = 16;
   localparam int unsigned NCO_CHAR_BITS = 10;

   // Registered output pair of the generator
   typedef struct packed {
      logic bit_tick;
      logic char_done;
   } nco_pulse_t;

endpackage

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
   parameter int unsigned ACC_W  = 20,
   parameter int unsigned STEP_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [STEP_W-1:0] step,
   output logic              wrap_d,
   output logic              tick_q
);
   localparam int unsigned SUM_W = ACC_W + 1;

   logic [ACC_W-1:0] phase_q;
   logic [SUM_W-1:0] sum;

   always_comb begin
      sum    = {1'b0, phase_q} + SUM_W'(step);
      wrap_d = sum[ACC_W];
   end

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         phase_q <= '0;
         tick_q  <= 1'b0;
      end else begin
         phase_q <= sum[ACC_W-1:0];
         tick_q  <= sum[ACC_W];
      end
   end
endmodule

// File: rtl/nco_char_counter.sv
module nco_char_counter #(
   parameter int unsigned CHAR_BITS = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic wrap_d,
   output logic done_q
);
   generate
      if (CHAR_BITS == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (rst || !en) done_q <= 1'b0;
            else            done_q <= wrap_d;
         end
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(CHAR_BITS);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_BITS - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst || !en) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else if (wrap_d) begin
               done_q <= (cnt_q == LAST);
               cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end else begin
               done_q <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/nco_baud_gen.sv
module nco_baud_gen
   import nco_baud_pkg::*;
#(
   parameter int unsigned ACC_W     = NCO_ACC_W,
   parameter int unsigned STEP_W    = NCO_STEP_W,
   parameter int unsigned CHAR_BITS = NCO_CHAR_BITS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [STEP_W-1:0] step,
   output logic              bit_tick,
   output logic              char_done
);
   generate
      if (STEP_W >= ACC_W) begin : g_bad_width
         $error("nco_baud_gen: STEP_W must be narrower than ACC_W");
      end
      if (CHAR_BITS < 1) begin : g_bad_char
         $error("nco_baud_gen: CHAR_BITS must be at least 1");
      end
   endgenerate

   logic       wrap_d;
   nco_pulse_t pulse;

   nco_phase_accum #(
      .ACC_W  (ACC_W),
      .STEP_W (STEP_W)
   ) u_accum (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .step   (step),
      .wrap_d (wrap_d),
      .tick_q (pulse.bit_tick)
   );

   nco_char_counter #(
      .CHAR_BITS (CHAR_BITS)
   ) u_chars (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .wrap_d (wrap_d),
      .done_q (pulse.char_done)
   );

   assign bit_tick  = pulse.bit_tick;
   assign char_done = pulse.char_done;
endmodule

// File: rtl/nco_baud_gen_chk.sv
module nco_baud_gen_chk #(
   parameter int unsigned STEP_W    = 16,
   parameter int unsigned CHAR_BITS = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              en,
   input logic [STEP_W-1:0] step,
   input logic              bit_tick,
   input logic              char_done
);
   int unsigned seen_q;
   logic        past_valid_q;

   always_ff @(posedge clk) begin
      if (rst) past_valid_q <= 1'b0;
      else     past_valid_q <= 1'b1;
      if (rst || !en)
         seen_q <= 0;
      else if (bit_tick)
         seen_q <= (seen_q == CHAR_BITS - 1) ? 0 : seen_q + 1;
   end

   // R1: outputs quiet on the first cycle after reset release
   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
      !past_valid_q |-> (!bit_tick && !char_done));

   // R2 / R8: a tick never lasts two cycles
   p_single_cycle_tick_r2: assert property (@(posedge clk) disable iff (rst)
      bit_tick |=> !bit_tick);

   // R4: zero step gives no tick
   p_zero_step_r4: assert property (@(posedge clk) disable iff (rst)
      (en && step == '0) |=> !bit_tick);

   // R5: done only with the tenth tick
   p_done_on_tenth_r5: assert property (@(posedge clk) disable iff (rst)
      char_done |-> (bit_tick && seen_q == CHAR_BITS - 1));

   // R5: the tenth tick always carries done
   p_tenth_has_done_r5: assert property (@(posedge clk) disable iff (rst)
      (bit_tick && seen_q == CHAR_BITS - 1) |-> char_done);

   // R6: disabled means silent
   p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !en |=> (!bit_tick && !char_done));
endmodule

bind nco_baud_gen nco_baud_gen_chk #(
   .STEP_W    (STEP_W),
   .CHAR_BITS (CHAR_BITS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .en        (en),
   .step      (step),
   .bit_tick  (bit_tick),
   .char_done (char_done)
);

// File: tb/nco_baud_gen_tb_top.sv
module nco_baud_gen_tb_top;
   localparam int unsigned CLK_PERIOD = 10;
   localparam longint unsigned MODULUS = 64'd1 << 20;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic [15:0] step = '0;
   logic        bit_tick;
   logic        char_done;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   string cur_req = "R1";

   // bench model
   longint unsigned m_acc = 0;
   int m_cnt = 0;
   bit m_tick = 0;
   bit m_done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nco_baud_gen dut_i (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .step      (step),
      .bit_tick  (bit_tick),
      .char_done (char_done)
   );

   function automatic bit carries(longint unsigned acc, longint unsigned s);
      return (acc + s) >= MODULUS;
   endfunction

   function automatic longint unsigned ticks_in(longint unsigned n, longint unsigned s);
      return (n * s) >> 20;
   endfunction

   always @(posedge clk) begin
      if (rst || !en) begin
         m_acc = 0; m_cnt = 0; m_tick = 0; m_done = 0;
      end else begin
         m_tick = carries(m_acc, 64'(step));
         m_acc  = (m_acc + 64'(step)) % MODULUS;
         m_done = 0;
         if (m_tick) begin
            if (m_cnt == 9) begin m_done = 1; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
         end
      end
   end

   task automatic check(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   int tick_sum = 0;
   int done_sum = 0;
   int prev_tick = 0;
   int double_ticks = 0;

   // advance n cycles, comparing against the model at each falling edge
   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(cur_req, "bit_tick", bit_tick, m_tick);
         check(cur_req, "char_done", char_done, m_done);
         tick_sum += bit_tick;
         done_sum += char_done;
         if (bit_tick && prev_tick) double_ticks++;
         prev_tick = bit_tick;
      end
   endtask

   task automatic clear_counts();
      tick_sum = 0; done_sum = 0; prev_tick = 0; double_ticks = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd12345));
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "tick in reset", bit_tick, 0);
      check("R1", "done in reset", char_done, 0);
      step = 16'd1000; en = 1'b1;
      @(negedge clk); rst = 1'b0;
      begin
         int lat = 0;
         bit got = 0;
         cur_req = "R1";
         while (!got && lat < 2000) begin
            run(1); lat++;
            if (bit_tick) got = 1;
         end
         // ceil(2^20/1000) = 1049 adds
         check("R1", "first tick latency", lat, 1049);
      end

      // R3: rate over a window from cleared phase
      en = 1'b0; run(1);
      step = 16'd4096; en = 1'b1; clear_counts();
      cur_req = "R3";
      run(4096);
      check("R3", "tick count step 4096", tick_sum, ticks_in(4096, 4096));
      // R5: sixteen ticks give one character
      check("R5", "done count", done_sum, 1);

      // R4: zero step
      step = 16'd0; clear_counts(); cur_req = "R4";
      run(500);
      check("R4", "ticks with zero step", tick_sum, 0);
      check("R4", "done with zero step", done_sum, 0);

      // R8: largest step
      en = 1'b0; run(1);
      step = 16'hFFFF; en = 1'b1; clear_counts(); cur_req = "R8";
      run(2048);
      check("R8", "tick count step ffff", tick_sum, ticks_in(2048, 16'hFFFF));
      check("R8", "back to back ticks", double_ticks, 0);
      check("R5", "done count ffff", done_sum, tick_sum / 10);

      // R6: disable clears phase; re-enable restarts timing
      en = 1'b0; clear_counts(); cur_req = "R6";
      run(50);
      check("R6", "ticks while disabled", tick_sum, 0);
      step = 16'd20000; en = 1'b1; clear_counts();
      run(53);
      // ceil(2^20/20000) = 53: exactly one tick, on the last cycle
      check("R6", "restart tick count", tick_sum, 1);
      check("R6", "restart tick position", bit_tick, 1);

      // R7: step change used on the next add
      en = 1'b0; run(1);
      step = 16'd50000; en = 1'b1; cur_req = "R7";
      run(20); // phase = 1000000, no tick yet
      check("R7", "no tick before change", bit_tick, 0);
      step = 16'd48576; // 1000000 + 48576 = 2^20 -> wraps now
      run(1);
      check("R7", "tick on first add with new step", bit_tick, 1);

      // R2/R5: random steps and enable toggles, per-cycle model compare
      cur_req = "R2";
      for (int seg = 0; seg < 60; seg++) begin
         step = 16'($urandom);
         if (($urandom % 8) == 0) step = 16'($urandom % 64);
         en = (($urandom % 6) != 0);
         run(200 + ($urandom % 600));
      end

      // R5 directed: exact tenth-tick alignment
      en = 1'b0; run(1);
      step = 16'd32768; en = 1'b1; clear_counts(); cur_req = "R5";
      run(640); // 20 ticks, 2 characters
      check("R5", "ticks step 8000h", tick_sum, 20);
      check("R5", "chars step 8000h", done_sum, 2);

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule